// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the tearing-effect line coming from a display panel, on which the panel signals both line timing and frame timing over one wire. Each pulse on that wire is timed in ticks of a divided clock. A short pulse is treated as a line (horizontal) sync and a long one as a frame (vertical) sync. A line counter is cleared by every frame sync and advanced by every line sync.

Once the programmed start condition is seen, the block emits a one-cycle active-low match strobe. The host uses the falling edge of that strobe to release a frame transfer it has been holding back, so the transfer starts in step with the panel's refresh. The line threshold is programmed in ticks minus one. The frame threshold is programmed in coarse units of eight ticks, minus one. Each measurement can see the pin inverted on its own.

Top module: `te_sync_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, `match_n` is 1.
- R2: Pulse widths are counted in ticks, with one tick every `clk_div`+1 clock cycles. With `clk_div`=0, a pulse that is active for N clock cycles measures exactly N ticks.
- R3: A pulse whose width in ticks is at least `hs_thr`+1 and below (`vs_thr`+1)*8 is a line sync, and it adds one to the line counter. A pulse narrower than `hs_thr`+1 ticks is ignored and does not move the line counter.
- R4: A pulse whose width in ticks is at least (`vs_thr`+1)*8 is a frame sync. It sets the line counter to 0 and arms the match for the new frame.
- R5: `hs_inv`=1 makes line-sync timing measure the low level of `te_in`. `vs_inv`=1 does the same for frame-sync timing. When an invert is 0, that measurement times the high level.
- R6: Mode values 0 and 1 (`mode[1]`=0) disable the block. No match is produced, and the line count and arming are cleared, so a frame sync is needed after the block is enabled again.
- R7: Mode 3 produces a match on every frame sync. Line syncs never produce a match in this mode.
- R8: Mode 2 produces a match when a sync brings the line counter equal to `target_line`, at most once per frame. A frame sync is needed to arm the match. With `target_line`=0, the frame sync itself matches.
- R9: A match drives `match_n` low for exactly one clock cycle. It falls on the third rising clock edge after `te_in` returns to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| te_in | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| mode | input | 2 | 0/1 off, 2 line match, 3 frame-sync match |
| target_line | input | 11 | Line count at which mode 2 matches |
| hs_thr | input | 3 | Minimum line-sync width in ticks, minus one |
| vs_thr | input | 9 | Minimum frame-sync width in units of 8 ticks, minus one |
| hs_inv | input | 1 | Invert pin level for line-sync timing |
| vs_inv | input | 1 | Invert pin level for frame-sync timing |
| clk_div | input | 3 | Tick period in clock cycles, minus one |
| match_n | output | 1 | Active-low one-cycle match strobe |

## Verification
Any fault in the width counters, the tick divider, the line counter or the arming flag reaches the ports only as a match strobe that is missing, extra or early. That strobe appears three clock edges after the trailing edge of the pulse that caused it. The bench therefore compares the running match count after each pulse, before the next pulse starts, so an error is pinned to the pulse that exposed it. Directed pulses sit exactly on the threshold boundaries with an undivided tick, and random widths are kept clear of tick-rounding ambiguity.

// File: rtl/te_pkg.sv
// Shared types for the tearing-effect sync detector.
// Assumes: mode encoding is fixed by the host programming model.
package te_pkg;
    typedef enum logic [1:0] {
        TE_OFF    = 2'd0,
        TE_RSVD   = 2'd1,
        TE_LINE   = 2'd2,
        TE_VSYNC  = 2'd3
    } te_mode_e;

    // Frame threshold unit is 2**VS_UNIT_LOG2 ticks.
    localparam int VS_UNIT_LOG2 = 3;
endpackage

// File: rtl/te_tick_gen.sv
// Tick generator: pulses tick once every div_sel+1 clock cycles.
// Assumes: div_sel is held stable while en is high.
module te_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = (phase >= div_sel);

    // Free-running phase counter, wraps at div_sel.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/te_width_meas.sv
// Pulse width meter: counts ticks while level is high and, on the
// cycle the level drops, presents pulse_end with the final width.
// Assumes: level is already synchronised to clk; width saturates.
module te_width_meas #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             level,
    input  logic             tick,
    output logic             pulse_end,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             level_q;
    logic [CNT_W-1:0] cnt;

    assign pulse_end = level_q && !level;
    assign width     = cnt;

    // Track previous level and accumulate ticks while active.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            level_q <= 1'b0;
            cnt     <= '0;
        end else begin
            level_q <= level;
            if (!level) begin
                cnt <= '0;
            end else if (tick && (cnt != CNT_MAX)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/te_line_match.sv
// Classifier, line counter and match logic. Turns measured pulse
// ends into line/frame sync events, keeps the line count since the
// last frame sync, and raises an active-low one-cycle match.
// Assumes: vs_ticks > hs_ticks; frame sync wins if both end together.
module te_line_match #(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  te_pkg::te_mode_e  mode,
    input  logic [LINE_W-1:0] target_line,
    input  logic [CNT_W-1:0]  hs_ticks,
    input  logic [CNT_W-1:0]  vs_ticks,
    input  logic              hs_end,
    input  logic [CNT_W-1:0]  hs_width,
    input  logic              vs_end,
    input  logic [CNT_W-1:0]  vs_width,
    output logic              hs_evt,
    output logic              vs_evt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              match_n
);
    import te_pkg::*;

    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic              en;
    logic              armed;
    logic              armed_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic              hit;

    assign en = mode[1];

    // Classify pulse ends by width against both thresholds.
    always_comb begin
        vs_evt = en && vs_end && (vs_width >= vs_ticks);
        hs_evt = en && hs_end && (hs_width >= hs_ticks) &&
                 (hs_width < vs_ticks) && !vs_evt;
    end

    // Next line count and arming after this cycle's event.
    always_comb begin
        if (vs_evt) begin
            line_nxt = '0;
        end else if (hs_evt && (line_cnt != LINE_MAX)) begin
            line_nxt = line_cnt + 1'b1;
        end else begin
            line_nxt = line_cnt;
        end
        armed_nxt = vs_evt ? 1'b1 : armed;
    end

    // Decide whether the start condition of the current mode is met.
    always_comb begin
        unique case (mode)
            TE_VSYNC: hit = vs_evt;
            TE_LINE:  hit = (vs_evt || hs_evt) && armed_nxt &&
                            (line_nxt == target_line);
            default:  hit = 1'b0;
        endcase
    end

    // Register count, arming and strobe; disabled mode clears all.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            line_cnt <= '0;
            armed    <= 1'b0;
            match_n  <= 1'b1;
        end else begin
            line_cnt <= line_nxt;
            armed    <= hit ? 1'b0 : armed_nxt;
            match_n  <= !hit;
        end
    end
endmodule

// File: rtl/te_sync_detect.sv
// Tearing-effect sync detector top. Synchronises the panel pin,
// measures pulse widths on two polarity-selectable channels (line
// and frame), and drives the active-low match strobe.
// Assumes: thresholds, divider and inverts change only while disabled.
module te_sync_detect #(
    parameter int LINE_W = 11,
    parameter int HS_W   = 3,
    parameter int VS_W   = 9,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] target_line,
    input  logic [HS_W-1:0]   hs_thr,
    input  logic [VS_W-1:0]   vs_thr,
    input  logic              hs_inv,
    input  logic              vs_inv,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              match_n
);
    import te_pkg::*;

    localparam int CNT_W  = VS_W + VS_UNIT_LOG2 + 1;
    localparam int N_CHAN = 2;   // channel 0: line, channel 1: frame

    te_mode_e          mode_e;
    logic              en;
    logic              te_meta;
    logic              te_s;
    logic              tick;
    logic [CNT_W-1:0]  hs_ticks;
    logic [CNT_W-1:0]  vs_ticks;
    logic [N_CHAN-1:0] chan_inv;
    logic [N_CHAN-1:0] chan_lvl;
    logic [N_CHAN-1:0] chan_end;
    logic [CNT_W-1:0]  chan_width [N_CHAN];
    logic              hs_evt;
    logic              vs_evt;
    logic [LINE_W-1:0] line_cnt;

    assign mode_e   = te_mode_e'(mode);
    assign en       = mode[1];
    assign hs_ticks = CNT_W'(hs_thr) + 1'b1;
    assign vs_ticks = (CNT_W'(vs_thr) + 1'b1) << VS_UNIT_LOG2;
    assign chan_inv = {vs_inv, hs_inv};

    // Two-stage synchroniser for the asynchronous panel pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_meta <= 1'b0;
            te_s    <= 1'b0;
        end else begin
            te_meta <= te_in;
            te_s    <= te_meta;
        end
    end

    te_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div_sel (clk_div),
        .tick    (tick)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        assign chan_lvl[g] = te_s ^ chan_inv[g];

        te_width_meas #(.CNT_W(CNT_W)) u_meas (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en),
            .level     (chan_lvl[g]),
            .tick      (tick),
            .pulse_end (chan_end[g]),
            .width     (chan_width[g])
        );
    end

    te_line_match #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_e),
        .target_line (target_line),
        .hs_ticks    (hs_ticks),
        .vs_ticks    (vs_ticks),
        .hs_end      (chan_end[0]),
        .hs_width    (chan_width[0]),
        .vs_end      (chan_end[1]),
        .vs_width    (chan_width[1]),
        .hs_evt      (hs_evt),
        .vs_evt      (vs_evt),
        .line_cnt    (line_cnt),
        .match_n     (match_n)
    );
endmodule

// File: rtl/te_sync_detect_chk.sv
// Property checker for te_sync_detect, bound to every instance.
// Assumes: observes ports plus the classifier events and line count.
module te_sync_detect_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] target_line,
    input logic              match_n,
    input logic              hs_evt,
    input logic              vs_evt,
    input logic [LINE_W-1:0] line_cnt
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    // R9
    match_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |=> match_n);

    // R6
    off_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> match_n);

    // R4
    frame_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> (line_cnt == '0));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_evt && (line_cnt != LINE_MAX)) |=>
        (line_cnt == LINE_W'($past(line_cnt) + 1'b1)));

    // R8
    line_match_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_n && ($past(mode) == 2'd2)) |-> (line_cnt == $past(target_line)));

    // R7
    vsync_match_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_n && ($past(mode) == 2'd3)) |-> (line_cnt == '0));
endmodule

bind te_sync_detect te_sync_detect_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .target_line (target_line),
    .match_n     (match_n),
    .hs_evt      (hs_evt),
    .vs_evt      (vs_evt),
    .line_cnt    (line_cnt)
);

// File: tb/te_sync_detect_bench.sv
`timescale 1ns/1ps
module te_sync_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_in = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [10:0] target_line = '0;
    logic [2:0]  hs_thr = '0;
    logic [8:0]  vs_thr = '0;
    logic        hs_inv = 1'b0;
    logic        vs_inv = 1'b0;
    logic [2:0]  clk_div = '0;
    logic        match_n;

    int checks = 0;
    int errors = 0;
    int nmatch = 0;
    int exp_n  = 0;
    int m_line = 0;
    bit m_armed = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    te_sync_detect u_te_sync_detect (
        .clk(clk), .rst_n(rst_n), .te_in(te_in), .mode(mode),
        .target_line(target_line), .hs_thr(hs_thr), .vs_thr(vs_thr),
        .hs_inv(hs_inv), .vs_inv(vs_inv), .clk_div(clk_div),
        .match_n(match_n)
    );

    // Count match strobes as seen between clock edges.
    always @(negedge clk) if (rst_n && !match_n) nmatch++;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog all-reqs actual %0d expected <150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int kind(input int ticks, input int hs_t, input int vs_t);
        if (ticks >= vs_t) return 2;
        if (ticks >= hs_t) return 1;
        return 0;
    endfunction

    function automatic int hs_ticks_f();
        return int'(hs_thr) + 1;
    endfunction

    function automatic int vs_ticks_f();
        return (int'(vs_thr) + 1) * 8;
    endfunction

    // Requirement model: advance expected matches for a classified pulse.
    task automatic model(input int k);
        if (!mode[1]) return;
        if (k == 2) begin
            m_line = 0;
            m_armed = 1'b1;
            if (mode == 2'd3 || target_line == 0) begin
                exp_n++;
                m_armed = 1'b0;
            end
        end else if (k == 1) begin
            if (m_line < 2047) m_line++;
            if (mode == 2'd2 && m_armed && m_line == int'(target_line)) begin
                exp_n++;
                m_armed = 1'b0;
            end
        end
    endtask

    // Drive one active pulse of w cycles, starting at a negedge.
    task automatic pulse(input int w);
        te_in = ~hs_inv;
        repeat (w) @(negedge clk);
        te_in = hs_inv;
    endtask

    task automatic send(input int w, input int k, input string tag);
        pulse(w);
        model(k);
        repeat (6) @(negedge clk);
        #1;
        chk(nmatch == exp_n, tag, nmatch, exp_n);
    endtask

    task automatic cfg(input logic [1:0] md, input int tgt, input int hs,
                       input int vs, input int dv, input bit inv);
        mode = 2'd0;
        repeat (3) @(negedge clk);
        target_line = 11'(tgt);
        hs_thr = 3'(hs);
        vs_thr = 9'(vs);
        clk_div = 3'(dv);
        hs_inv = inv;
        vs_inv = inv;
        te_in = inv;
        repeat (3) @(negedge clk);
        m_line = 0;
        m_armed = 1'b0;
        mode = md;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h7e51));
        repeat (3) @(negedge clk);
        // R1: strobe idle during reset
        chk(match_n == 1'b1, "R1 during reset", match_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(match_n == 1'b1, "R1 after reset", match_n, 1);

        // R2/R4/R7: exact boundaries, undivided tick, hs=3 ticks, vs=16 ticks
        cfg(2'd3, 0, 2, 1, 0, 1'b0);
        send(15, 1, "R3 width 15 is line sync, R7 no match");
        send(16, 2, "R4 width 16 is frame sync, R7 match");
        send(2, 0, "R3 glitch width 2 ignored");

        // R9: exact strobe timing on a frame sync
        te_in = 1'b1;
        repeat (16) @(negedge clk);
        te_in = 1'b0;
        @(negedge clk); chk(match_n == 1'b1, "R9 edge1 high", match_n, 1);
        @(negedge clk); chk(match_n == 1'b1, "R9 edge2 high", match_n, 1);
        @(negedge clk); chk(match_n == 1'b0, "R9 edge3 low", match_n, 0);
        @(negedge clk); chk(match_n == 1'b1, "R9 edge4 high again", match_n, 1);
        model(2);
        repeat (3) @(negedge clk);

        // R3: glitch does not advance the line count
        cfg(2'd2, 1, 2, 1, 0, 1'b0);
        send(16, 2, "R8 frame sync target1 no match");
        send(2, 0, "R3 glitch no count");
        send(3, 1, "R3 width 3 line sync reaches line 1");

        // R8: arming, once per frame, target 0
        cfg(2'd2, 2, 1, 1, 0, 1'b0);
        send(5, 1, "R8 unarmed line sync");
        send(5, 1, "R8 unarmed line sync 2");
        send(20, 2, "R8 frame sync arms");
        send(5, 1, "R8 line 1");
        send(5, 1, "R8 line 2 match");
        send(5, 1, "R8 once per frame");
        cfg(2'd2, 0, 1, 1, 0, 1'b0);
        send(20, 2, "R8 target 0 matches on frame sync");
        send(5, 1, "R8 target 0 no line match");

        // R6: disabled modes
        cfg(2'd0, 0, 1, 1, 0, 1'b0);
        send(20, 2, "R6 mode 0 no match");
        cfg(2'd1, 0, 1, 1, 0, 1'b0);
        send(20, 2, "R6 mode 1 no match");

        // R5: inverted polarity, low pulses
        cfg(2'd3, 0, 2, 1, 0, 1'b1);
        send(16, 2, "R5 inverted frame sync matches");
        send(8, 1, "R5 inverted line sync no match");

        // R2: divided tick, 4 cycles per tick, vs=16 ticks
        cfg(2'd3, 0, 2, 1, 3, 1'b0);
        send(40, 1, "R2 40 cycles is 10 ticks, line sync");
        send(80, 2, "R2 80 cycles is 20 ticks, frame sync");

        // Random phase: R2 R3 R4 R7 R8
        for (int c = 0; c < 7; c++) begin
            int hs = $urandom % 8;
            int vs = $urandom % 4;
            int dv = $urandom % 4;
            bit inv = 1'($urandom % 2);
            logic [1:0] md = ($urandom % 2) ? 2'd2 : 2'd3;
            if (vs == 0 && hs == 7) hs = 6;
            cfg(md, $urandom % 4, hs, vs, dv, inv);
            for (int p = 0; p < 40; p++) begin
                int w = 1;
                int k = 0;
                int d1 = dv + 1;
                for (int t = 0; t < 200; t++) begin
                    int lo;
                    int hi;
                    if ($urandom % 10 < 3)
                        w = vs_ticks_f() * d1 + ($urandom % (8 * d1));
                    else
                        w = 1 + ($urandom % (vs_ticks_f() * d1));
                    lo = w / d1;
                    hi = (w + dv) / d1;
                    k = kind(lo, hs_ticks_f(), vs_ticks_f());
                    if (k == kind(hi, hs_ticks_f(), vs_ticks_f())) break;
                end
                send(w, k, "R2 R3 R4 R7 R8 random pulse");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule